// File: doc/BRIEF.md
# Sector Data Byte Buffer

This block is the byte store behind the data port of a disk interface. It is a circular byte buffer. The host side moves 1, 2 or 4 bytes per access. The media side moves one byte per cycle. An endianness input selects how a wide host access maps onto the byte stream. For reads, it decides which end of the host word the first byte popped lands in. For writes, it decides which byte of the host word is pushed first.

The block watches sector boundaries, one sector being 512 bytes. When a host read leaves the read pointer on a sector boundary and data is still waiting, it raises an interrupt request. A write job is armed with a sector count and a single or multi-sector mode. In that job the block tracks how many bytes the host has written since the last commit. When enough bytes have gathered, it pulses a commit request with the number of sectors to take, and the media side then drains them. Every commit also raises an interrupt request.

A host access is sequenced one byte per clock through a single-write, single-read block memory. The host and media ports are therefore served only while the engine is idle.

Top module: `sect_buf`

## Requirements
- R1: Bytes leave the buffer in the order they entered. The write and read pointers wrap modulo DEPTH, so data stays intact across the wrap. The byte count (`level`) never exceeds DEPTH.
- R2: `host_size` encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A host read pops that many bytes. With `big_endian` low, the first byte popped lands in bits 7:0. With it high, the first byte lands in the most significant byte of the access (bits 15:8 for 2 bytes, bits 31:24 for 4 bytes). Bits above the access width read as zero. `host_done` pulses for one cycle when the access completes.
- R3: A host write pushes the bytes of `host_wdata` that the access width covers. With `big_endian` low, bits 7:0 go first and the top byte goes last. With it high, the order is reversed. A 1-byte write pushes bits 7:0.
- R4: When a host read completes, `irq_req` pulses in the `host_done` cycle if and only if the buffer is not empty and the total number of bytes popped since reset is a multiple of 512.
- R5: In single-sector write mode, a host write that leaves the bytes gathered since the last commit at a non-zero multiple of 512 pulses `commit_req` with `commit_secs` = 1, in its `host_done` cycle.
- R6: In multi-sector write mode, `commit_req` pulses when the gathered byte count equals 512 times the remaining sector count, and `commit_secs` equals that remaining count. A sector count of 0 given at `wr_begin` means 256.
- R7: Each commit lowers the remaining sector count by the sectors committed. `wr_active` falls when the count reaches zero. Every commit also pulses `irq_req`.
- R8: `drq` is high whenever the buffer holds data or a write job is active.
- R9: A push into a full buffer drops the byte, leaves `level` unchanged and sets the sticky `overrun` flag.
- R10: A pop from an empty buffer returns 0xFF, leaves `level` unchanged and sets the sticky `underrun` flag.
- R11: `med_push` appends `med_wdata`. `med_pop` removes one byte, which appears on `med_rdata` with `med_rvalid` in the next cycle.
- R12: After reset the buffer is empty, no write job is active, all flags and pulses are low, and both ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Byte order for host accesses, latched when an access starts |
| host_rd | input | 1 | Start a host read (taken when host_ready) |
| host_wr | input | 1 | Start a host write (taken when host_ready; wins over host_rd) |
| host_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| host_wdata | input | 32 | Host write word |
| host_ready | output | 1 | Engine idle, a host access may start |
| host_done | output | 1 | One-cycle pulse at access completion |
| host_rdata | output | 32 | Packed read word, valid with host_done of a read |
| med_push | input | 1 | Media byte push |
| med_wdata | input | 8 | Media byte to push |
| med_pop | input | 1 | Media byte pop |
| med_ready | output | 1 | Media operations are accepted |
| med_rvalid | output | 1 | Popped media byte valid |
| med_rdata | output | 8 | Popped media byte |
| wr_begin | input | 1 | Arm a write job |
| wr_multi | input | 1 | Write job mode: 1 multi-sector, 0 single-sector |
| wr_secs | input | 8 | Sectors in the write job (0 means 256) |
| wr_active | output | 1 | Write job in progress |
| commit_req | output | 1 | One-cycle commit pulse |
| commit_secs | output | 9 | Sectors to commit, valid with commit_req |
| irq_req | output | 1 | Interrupt request pulse |
| drq | output | 1 | Data request status |
| level | output | 11 | Bytes held in the buffer |
| overrun | output | 1 | Sticky push-when-full flag |
| underrun | output | 1 | Sticky pop-when-empty flag |

## Verification
The assertions take three things for granted about the inputs. A host access starts only while `host_ready` is high. Media pushes and pops arrive only while `med_ready` is high and no host request is present in the same cycle. DEPTH is a power of two no smaller than 1024, so the read-pointer offset within a sector matches the count of bytes popped. The bench keeps to these rules. Every host task waits for `host_ready` before it drives a request. Media operations are issued only between host accesses. Only the default depth is used.

// File: rtl/sect_buf_pkg.sv
package sect_buf_pkg;

  localparam int unsigned SECTOR_SHIFT = 9;
  localparam int unsigned SECTOR_BYTES = 1 << SECTOR_SHIFT;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_FIN  = 2'd2
  } eng_state_t;

  // number of bytes moved by one host access
  function automatic logic [2:0] width_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // rearrange a host word so that bits 7:0 hold the first byte to push
  function automatic logic [31:0] push_order(input logic [31:0] d,
                                             input logic [1:0]  sz,
                                             input logic        be);
    logic [31:0] r;
    r = d;
    if (be) begin
      case (sz)
        2'd0:    r = {24'h0, d[7:0]};
        2'd1:    r = {16'h0, d[7:0], d[15:8]};
        default: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/sect_buf_ram.sv
module sect_buf_ram #(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sect_buf_ring.sv
module sect_buf_ring
  import sect_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  logic [7:0]              push_byte,
  input  logic                    pop,
  output logic [7:0]              pop_byte,
  output logic [$clog2(DEPTH):0]  head,
  output logic [SECTOR_SHIFT-1:0] tail_sec,
  output logic [$clog2(DEPTH):0]  level,
  output logic                    empty,
  output logic                    overrun,
  output logic                    underrun
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] tail;
  logic          full, do_push, do_pop, miss_q;
  logic [7:0]    ram_q;

  assign level    = head - tail;
  assign full     = (level == PW'(DEPTH));
  assign empty    = (level == '0);
  assign do_push  = push & ~full;
  assign do_pop   = pop & ~empty;
  assign tail_sec = tail[SECTOR_SHIFT-1:0];
  assign pop_byte = miss_q ? 8'hFF : ram_q;

  sect_buf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (do_push),
    .waddr (head[AW-1:0]),
    .wdata (push_byte),
    .raddr (tail[AW-1:0]),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      overrun  <= 1'b0;
      underrun <= 1'b0;
      miss_q   <= 1'b0;
    end else begin
      head     <= head + PW'(do_push);
      tail     <= tail + PW'(do_pop);
      overrun  <= overrun | (push & full);
      underrun <= underrun | (pop & empty);
      miss_q   <= pop & empty;
    end
  end

  // R9
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (head == $past(head) && overrun));

  // R10
  empty_pop_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (pop_byte == 8'hFF && underrun));

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= PW'(DEPTH));

endmodule

// File: rtl/sect_buf_pack.sv
module sect_buf_pack
  import sect_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    big_endian,
  input  logic                    host_rd,
  input  logic                    host_wr,
  input  logic [1:0]              host_size,
  input  logic [31:0]             host_wdata,
  output logic                    host_ready,
  output logic                    host_done,
  output logic [31:0]             host_rdata,
  output logic                    rd_irq,
  output logic                    wr_fin,
  input  logic                    med_push,
  input  logic [7:0]              med_wdata,
  input  logic                    med_pop,
  output logic                    med_ready,
  output logic                    med_rvalid,
  output logic                    push,
  output logic [7:0]              push_byte,
  output logic                    pop,
  input  logic [7:0]              pop_byte,
  input  logic [$clog2(DEPTH):0]  level,
  input  logic [SECTOR_SHIFT-1:0] tail_sec
);

  eng_state_t  st;
  logic        is_rd, be_q, eng_pop_q, med_pop_q;
  logic [2:0]  left;
  logic [1:0]  idx;
  logic [31:0] sreg, acc, acc_next;
  logic        idle, take_wr, take_rd, med_go;

  assign idle       = (st == ENG_IDLE);
  assign take_wr    = idle & host_wr;
  assign take_rd    = idle & host_rd & ~host_wr;
  assign med_go     = idle & ~host_wr & ~host_rd;
  assign host_ready = idle;
  assign med_ready  = idle;
  assign med_rvalid = med_pop_q;
  assign wr_fin     = (st == ENG_FIN) & ~is_rd;

  // one byte operation per cycle: engine while running, media while idle
  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    push_byte = 8'h00;
    if (st == ENG_RUN) begin
      if (is_rd) begin
        pop = 1'b1;
      end else begin
        push      = 1'b1;
        push_byte = sreg[7:0];
      end
    end else if (med_go) begin
      push      = med_push;
      push_byte = med_wdata;
      pop       = med_pop;
    end
  end

  // gather popped bytes into the host word
  always_comb begin
    acc_next = acc;
    if (eng_pop_q) begin
      if (be_q) acc_next = {acc[23:0], pop_byte};
      else      acc_next = acc | ({24'h0, pop_byte} << {idx, 3'b000});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ENG_IDLE;
      is_rd      <= 1'b0;
      be_q       <= 1'b0;
      left       <= '0;
      idx        <= '0;
      sreg       <= '0;
      acc        <= '0;
      eng_pop_q  <= 1'b0;
      med_pop_q  <= 1'b0;
      host_done  <= 1'b0;
      host_rdata <= '0;
      rd_irq     <= 1'b0;
    end else begin
      eng_pop_q <= (st == ENG_RUN) & is_rd;
      med_pop_q <= med_go & med_pop;
      host_done <= 1'b0;
      rd_irq    <= 1'b0;
      acc       <= acc_next;
      if (eng_pop_q) idx <= idx + 2'd1;
      case (st)
        ENG_IDLE: begin
          if (take_wr | take_rd) begin
            is_rd <= take_rd;
            be_q  <= big_endian;
            left  <= width_bytes(host_size);
            sreg  <= push_order(host_wdata, host_size, big_endian);
            acc   <= '0;
            idx   <= '0;
            st    <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          sreg <= sreg >> 8;
          left <= left - 3'd1;
          if (left == 3'd1) st <= ENG_FIN;
        end
        default: begin
          st        <= ENG_IDLE;
          host_done <= 1'b1;
          if (is_rd) begin
            host_rdata <= acc_next;
            rd_irq     <= (level != '0) && (tail_sec == '0);
          end
        end
      endcase
    end
  end

  // R2
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R4
  read_irq_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    rd_irq |-> (level != '0 && tail_sec == '0));

endmodule

// File: rtl/sect_buf_commit.sv
module sect_buf_commit
  import sect_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned SEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_begin,
  input  logic                   wr_multi,
  input  logic [SEC_W-1:0]       wr_secs,
  input  logic                   check,
  input  logic [$clog2(DEPTH):0] head,
  output logic                   active,
  output logic                   commit_req,
  output logic [SEC_W:0]         commit_secs
);

  localparam int unsigned PW = $clog2(DEPTH) + 1;
  localparam int unsigned TW = SEC_W + 1 + SECTOR_SHIFT;
  localparam int unsigned CW = ((PW > TW) ? PW : TW) + 1;

  logic [SEC_W:0] rem, step;
  logic           multi_q, hit;
  logic [PW-1:0]  mark, gathered;
  logic [CW-1:0]  target;

  assign gathered = head - mark;
  assign target   = multi_q ? (CW'(rem) << SECTOR_SHIFT) : CW'(SECTOR_BYTES);
  assign step     = multi_q ? rem : (SEC_W+1)'(1);
  assign hit      = check & active & (gathered != '0) &
                    (multi_q ? (CW'(gathered) == target)
                             : (gathered[SECTOR_SHIFT-1:0] == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      multi_q     <= 1'b0;
      rem         <= '0;
      mark        <= '0;
      commit_req  <= 1'b0;
      commit_secs <= '0;
    end else begin
      commit_req <= 1'b0;
      if (wr_begin) begin
        active  <= 1'b1;
        multi_q <= wr_multi;
        rem     <= (wr_secs == '0) ? {1'b1, {SEC_W{1'b0}}} : {1'b0, wr_secs};
        mark    <= head;
      end else if (hit) begin
        commit_req  <= 1'b1;
        commit_secs <= step;
        rem         <= rem - step;
        mark        <= mark + PW'(CW'(step) << SECTOR_SHIFT);
        if (rem == step) active <= 1'b0;
      end
    end
  end

  // R7
  active_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> commit_req);

  // R5
  commit_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> ($past(check) && commit_secs != '0));

endmodule

// File: rtl/sect_buf.sv
module sect_buf
  import sect_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned SEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   big_endian,
  input  logic                   host_rd,
  input  logic                   host_wr,
  input  logic [1:0]             host_size,
  input  logic [31:0]            host_wdata,
  output logic                   host_ready,
  output logic                   host_done,
  output logic [31:0]            host_rdata,
  input  logic                   med_push,
  input  logic [7:0]             med_wdata,
  input  logic                   med_pop,
  output logic                   med_ready,
  output logic                   med_rvalid,
  output logic [7:0]             med_rdata,
  input  logic                   wr_begin,
  input  logic                   wr_multi,
  input  logic [SEC_W-1:0]       wr_secs,
  output logic                   wr_active,
  output logic                   commit_req,
  output logic [SEC_W:0]         commit_secs,
  output logic                   irq_req,
  output logic                   drq,
  output logic [$clog2(DEPTH):0] level,
  output logic                   overrun,
  output logic                   underrun
);

  localparam int unsigned PW = $clog2(DEPTH) + 1;

  logic                    push, pop, empty, rd_irq, wr_fin;
  logic [7:0]              push_byte, pop_byte;
  logic [PW-1:0]           head;
  logic [SECTOR_SHIFT-1:0] tail_sec;

  sect_buf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_byte (push_byte),
    .pop       (pop),
    .pop_byte  (pop_byte),
    .head      (head),
    .tail_sec  (tail_sec),
    .level     (level),
    .empty     (empty),
    .overrun   (overrun),
    .underrun  (underrun)
  );

  sect_buf_pack #(.DEPTH(DEPTH)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .big_endian (big_endian),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_size  (host_size),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_done  (host_done),
    .host_rdata (host_rdata),
    .rd_irq     (rd_irq),
    .wr_fin     (wr_fin),
    .med_push   (med_push),
    .med_wdata  (med_wdata),
    .med_pop    (med_pop),
    .med_ready  (med_ready),
    .med_rvalid (med_rvalid),
    .push       (push),
    .push_byte  (push_byte),
    .pop        (pop),
    .pop_byte   (pop_byte),
    .level      (level),
    .tail_sec   (tail_sec)
  );

  sect_buf_commit #(.DEPTH(DEPTH), .SEC_W(SEC_W)) u_commit (
    .clk         (clk),
    .rst         (rst),
    .wr_begin    (wr_begin),
    .wr_multi    (wr_multi),
    .wr_secs     (wr_secs),
    .check       (wr_fin),
    .head        (head),
    .active      (wr_active),
    .commit_req  (commit_req),
    .commit_secs (commit_secs)
  );

  assign med_rdata = pop_byte;
  assign irq_req   = rd_irq | commit_req;
  assign drq       = ~empty | wr_active;

  // R4
  irq_with_access_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> host_done);

endmodule

// File: tb/sim_sect_buf.sv
module sim_sect_buf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_size = 2'd0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, host_done;
  logic [31:0] host_rdata;
  logic        med_push = 1'b0, med_pop = 1'b0;
  logic [7:0]  med_wdata = '0;
  logic        med_ready, med_rvalid;
  logic [7:0]  med_rdata;
  logic        wr_begin = 1'b0, wr_multi = 1'b0;
  logic [7:0]  wr_secs = '0;
  logic        wr_active, commit_req, irq_req, drq, overrun, underrun;
  logic [8:0]  commit_secs;
  logic [10:0] level;

  int vecs = 0;
  int errs = 0;
  int cons = 0;

  always #4 clk = ~clk;

  sect_buf u0 (
    .clk(clk), .rst(rst), .big_endian(big_endian),
    .host_rd(host_rd), .host_wr(host_wr), .host_size(host_size),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_done(host_done),
    .host_rdata(host_rdata), .med_push(med_push), .med_wdata(med_wdata),
    .med_pop(med_pop), .med_ready(med_ready), .med_rvalid(med_rvalid),
    .med_rdata(med_rdata), .wr_begin(wr_begin), .wr_multi(wr_multi),
    .wr_secs(wr_secs), .wr_active(wr_active), .commit_req(commit_req),
    .commit_secs(commit_secs), .irq_req(irq_req), .drq(drq), .level(level),
    .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_op(input bit wr, input logic [1:0] sz, input bit be,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output bit irq, output bit cm, output logic [8:0] cs);
    while (!host_ready) @(negedge clk);
    big_endian = be; host_size = sz; host_wdata = wd;
    host_wr = wr; host_rd = !wr;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    while (!host_done) @(negedge clk);
    rd = host_rdata; irq = irq_req; cm = commit_req; cs = commit_secs;
    @(negedge clk);
  endtask

  task automatic mpush(input logic [7:0] b);
    med_push = 1'b1; med_wdata = b;
    @(negedge clk);
    med_push = 1'b0;
  endtask

  task automatic mpop(output logic [7:0] b, output bit v);
    med_pop = 1'b1;
    @(negedge clk);
    med_pop = 1'b0;
    b = med_rdata; v = med_rvalid;
  endtask

  task automatic arm(input bit multi, input logic [7:0] secs);
    wr_multi = multi; wr_secs = secs; wr_begin = 1'b1;
    @(negedge clk);
    wr_begin = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic t_reset();
    chk("R12 level", 32'(level), 0);
    chk("R12 drq", 32'(drq), 0);
    chk("R12 flags", {30'h0, overrun, underrun}, 0);
    chk("R12 ready", {30'h0, host_ready, med_ready}, 32'h3);
    chk("R12 pulses", {29'h0, irq_req, commit_req, host_done}, 0);
    chk("R12 wr_active", 32'(wr_active), 0);
  endtask

  task automatic t_read_pack();
    logic [31:0] rd; bit irq, cm; logic [8:0] cs; logic [7:0] b; bit v;
    mpush(8'h11); mpush(8'h22); mpush(8'h33); mpush(8'h44);
    chk("R11 level after media pushes", 32'(level), 4);
    host_op(0, 2'd2, 0, 0, rd, irq, cm, cs); cons += 4;
    chk("R2 LE 4-byte read", rd, 32'h44332211);
    chk("R4 no irq when empty", 32'(irq), 0);
    mpush(8'h11); mpush(8'h22); mpush(8'h33); mpush(8'h44);
    host_op(0, 2'd3, 1, 0, rd, irq, cm, cs); cons += 4;
    chk("R2 BE 4-byte read", rd, 32'h11223344);
    mpush(8'hAA); mpush(8'hBB);
    host_op(0, 2'd0, 0, 0, rd, irq, cm, cs); cons += 1;
    chk("R2 LE 1-byte read", rd, 32'h000000AA);
    host_op(0, 2'd0, 1, 0, rd, irq, cm, cs); cons += 1;
    chk("R2 BE 1-byte read", rd, 32'h000000BB);
    mpush(8'h01); mpush(8'h02);
    host_op(0, 2'd1, 1, 0, rd, irq, cm, cs); cons += 2;
    chk("R2 BE 2-byte read", rd, 32'h00000102);
    mpush(8'h01); mpush(8'h02);
    host_op(0, 2'd1, 0, 0, rd, irq, cm, cs); cons += 2;
    chk("R2 LE 2-byte read", rd, 32'h00000201);
    mpush(8'h5A);
    mpop(b, v); cons += 1;
    chk("R11 media pop byte", {23'h0, v, b}, {23'h0, 1'b1, 8'h5A});
  endtask

  task automatic t_write_pack();
    logic [31:0] rd; bit irq, cm; logic [8:0] cs; logic [7:0] b; bit v;
    logic [31:0] got;
    host_op(1, 2'd2, 0, 32'hA1B2C3D4, rd, irq, cm, cs);
    got = '0;
    for (int k = 0; k < 4; k++) begin mpop(b, v); got = {got[23:0], b}; end
    cons += 4;
    chk("R3 LE 4-byte push order", got, 32'hD4C3B2A1);
    host_op(1, 2'd2, 1, 32'hA1B2C3D4, rd, irq, cm, cs);
    got = '0;
    for (int k = 0; k < 4; k++) begin mpop(b, v); got = {got[23:0], b}; end
    cons += 4;
    chk("R3 BE 4-byte push order", got, 32'hA1B2C3D4);
    host_op(1, 2'd1, 1, 32'hFFFF1234, rd, irq, cm, cs);
    chk("R3 2-byte write level", 32'(level), 2);
    got = '0;
    for (int k = 0; k < 2; k++) begin mpop(b, v); got = {got[23:0], b}; end
    cons += 2;
    chk("R3 BE 2-byte push order", got, 32'h00001234);
    host_op(1, 2'd0, 0, 32'hCCDDEE77, rd, irq, cm, cs);
    chk("R3 1-byte write level", 32'(level), 1);
    mpop(b, v); cons += 1;
    chk("R3 1-byte push", 32'(b), 32'h77);
  endtask

  task automatic t_wrap_overrun();
    logic [31:0] rd, exp; bit irq, cm; logic [8:0] cs; logic [7:0] b; bit v;
    int lvl; int bad; int irqs;
    mpush(8'h00); mpush(8'h00); mpop(b, v); mpop(b, v); cons += 2;
    for (int i = 0; i < 1024; i++) mpush(pat(i));
    chk("R1 full level", 32'(level), 1024);
    chk("R9 no overrun yet", 32'(overrun), 0);
    mpush(8'hEE);
    chk("R9 overrun sticky", 32'(overrun), 1);
    chk("R9 level unchanged", 32'(level), 1024);
    lvl = 1024; bad = 0; irqs = 0;
    for (int k = 0; k < 256; k++) begin
      host_op(0, 2'd2, 0, 0, rd, irq, cm, cs);
      cons += 4; lvl -= 4;
      exp = {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
      chk("R1 wrapped read data", rd, exp);
      chk("R4 read irq", 32'(irq), 32'(((cons % 512) == 0) && (lvl != 0)));
      if (irq) irqs++;
    end
    chk("R4 irq count over two sectors", 32'(irqs), 2);
    host_op(0, 2'd0, 0, 0, rd, irq, cm, cs);
    chk("R10 empty read byte", rd, 32'h000000FF);
    chk("R10 underrun sticky", 32'(underrun), 1);
    chk("R10 level stays zero", 32'(level), 0);
  endtask

  task automatic drain(input int n, input int base, input string req);
    logic [7:0] b; bit v; int bad;
    bad = 0;
    for (int j = 0; j < n; j++) begin
      mpop(b, v);
      if (!v || b !== 8'((base + j) & 255)) bad++;
    end
    cons += n;
    chk(req, 32'(bad), 0);
  endtask

  task automatic write_words(input int first, input int n, input int commit_at,
                             input logic [8:0] exp_secs, input string req);
    logic [31:0] rd, wd; bit irq, cm; logic [8:0] cs;
    for (int i = first; i < first + n; i++) begin
      wd = {8'((4*i+3) & 255), 8'((4*i+2) & 255), 8'((4*i+1) & 255), 8'((4*i) & 255)};
      host_op(1, 2'd2, 0, wd, rd, irq, cm, cs);
      chk(req, 32'(cm), 32'(i == commit_at));
      if (i == commit_at) begin
        chk("R7 commit raises irq", 32'(irq), 1);
        chk(req, 32'(cs), 32'(exp_secs));
      end
    end
  endtask

  task automatic t_single();
    arm(0, 8'd2);
    chk("R8 drq while job active and empty", 32'(drq), 1);
    write_words(0, 128, 127, 9'd1, "R5 single commit");
    chk("R7 still active after first sector", 32'(wr_active), 1);
    drain(512, 0, "R5 committed bytes");
    write_words(128, 128, 255, 9'd1, "R5 single commit");
    chk("R7 active cleared at zero", 32'(wr_active), 0);
    drain(512, 512, "R5 committed bytes");
    chk("R8 drq low when idle and empty", 32'(drq), 0);
  endtask

  task automatic t_multi();
    arm(1, 8'd2);
    write_words(0, 256, 255, 9'd2, "R6 multi commit");
    chk("R6 level at multi commit", 32'(level), 1024);
    chk("R7 multi job cleared", 32'(wr_active), 0);
    drain(1024, 0, "R6 committed bytes");
  endtask

  task automatic t_zero_count();
    arm(0, 8'd0);
    write_words(0, 128, 127, 9'd1, "R6 zero count single commit");
    chk("R6 zero count means 256", 32'(wr_active), 1);
    drain(512, 0, "R6 committed bytes");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_pack();
    t_write_pack();
    t_wrap_overrun();
    t_single();
    t_multi();
    t_zero_count();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule